// File: doc/BRIEF.md
# SPI Serial EEPROM Slave with Block Write Protection

This block is the slave end of a 2 KiB serial EEPROM on an SPI bus using clock mode 0. The serial clock, chip select, data-in, hold and write-protect pins are sampled by a faster system clock. The block decodes an 8-bit instruction and, for array accesses, a 16-bit address, of which the low 11 bits are used. It holds a status register with a busy flag, a write enable latch and two block protect bits, plus the byte array itself.

A write is only a request until chip select goes high. At that point the block checks four things: how many clock pulses the frame carried, whether the latch was set, whether write protect is active, and whether the target address is protected. Only if all pass does it commit. After a commit the block stays busy for a fixed number of system clocks, and during that time it serves only status reads. A hold input pauses the transfer, but only when it is asserted while the serial clock is low.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the status byte reads 0x00 and `miso_en` is low.
- R2: Opcode 0x06, sent alone in a frame of exactly 8 clock pulses, sets the write enable latch. Opcode 0x04, sent the same way, clears it. Opcode 0x05 returns the status byte MSB first and repeats it for every following byte. The status byte is laid out as: bit 0 busy, bit 1 latch, bits 3:2 protect code, all other bits 0.
- R3: Opcode 0x03 followed by a 16-bit address returns array bytes MSB first from that address on. The address increments after each byte and wraps from 0x7FF to 0x000.
- R4: Opcode 0x02, a 16-bit address and a data byte store that first data byte when chip select rises, provided all checks pass. Every write frame, whether it commits or not, leaves the latch cleared.
- R5: A write frame whose clock pulse count is not a multiple of 8 changes nothing except clearing the latch.
- R6: A write or status write is rejected when the latch is clear.
- R7: The protect code selects the read-only range. 00 protects nothing, 01 protects 0x600–0x7FF, 10 protects 0x400–0x7FF, and 11 protects the whole array. Writes into the protected range are rejected.
- R8: Opcode 0x01 followed by a data byte loads the protect code from data bits 3:2. While `wp_n` is low the protect code keeps its value, and the latch is still cleared.
- R9: A committed write or status write keeps the busy bit at 1 for BUSY_CYC system clocks. During that time every frame except a status read is ignored.
- R10: Hold begins only while `sck` is low. While it is active, clock edges are ignored and `miso_en` is low. The transfer continues intact after hold is released.
- R11: `miso_en` is low whenever `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock that samples the serial pins |
| rst_n | input | 1 | active-low reset |
| sck | input | 1 | serial clock, mode 0 |
| cs_n | input | 1 | active-low chip select |
| mosi | input | 1 | serial data in |
| hold_n | input | 1 | active-low pause |
| wp_n | input | 1 | active-low lock of the protect code |
| miso | output | 1 | serial data out |
| miso_en | output | 1 | output enable for `miso` (high = driving) |

## Verification
The hardest state to reach is a frame that starts while an internal write is still running. The bench sets a long busy window on the instance. It then sends a latch-enable frame and a status read right after a committed write, with no pause between them, and confirms that the busy bit is set and the latch stayed clear. A second case that is hard to reach is a write frame carrying a stray pulse count. The transfer task appends extra clock pulses after the last whole byte to produce it. The hold pause is placed in the middle of a read's output phase, with decoy clock pulses sent during the pause.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int AW       = 11,
  parameter int BUSY_CYC = 64,
  localparam int BCW     = $clog2(BUSY_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  input  logic hold_n,
  input  logic wp_n,
  output logic miso,
  output logic miso_en
);
  localparam logic [7:0] OP_WRSR = 8'h01, OP_WRITE = 8'h02, OP_READ = 8'h03,
                         OP_WRDI = 8'h04, OP_RDSR  = 8'h05, OP_WREN  = 8'h06;

  logic [7:0]    mem [2**AW];
  logic          sck_q, cs_q, hold_act, wel, blk;
  logic [1:0]    bp;
  logic [15:0]   cnt, sh;
  logic [7:0]    op, data, osh;
  logic [AW-1:0] addr;
  logic [BCW-1:0] busy_cnt;

  wire live   = ~cs_n & ~hold_act;
  wire rise   = live & sck & ~sck_q;
  wire fall   = live & ~sck & sck_q;
  wire busy   = busy_cnt != '0;
  wire desel  = cs_n & ~cs_q;
  wire has_op = cnt >= 16'd8;
  wire [7:0] status = {4'b0, bp, wel, busy};

  wire prot = (bp == 2'b11) | (bp == 2'b10 & addr[AW-1]) |
              (bp == 2'b01 & addr[AW-1:AW-2] == 2'b11);

  wire end_ok = desel & ~blk & has_op & (cnt[2:0] == 3'd0);
  wire we     = end_ok & op == OP_WRITE & cnt >= 16'd32 & wel & ~prot;
  wire sr_we  = end_ok & op == OP_WRSR  & cnt >= 16'd16 & wel;
  wire wr_frm = desel & ~blk & has_op & (op == OP_WRITE | op == OP_WRSR);

  wire out_phase = has_op & ((op == OP_RDSR) | (op == OP_READ & cnt >= 16'd24 & ~blk));

  assign miso    = osh[7];
  assign miso_en = live & out_phase;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; hold_act <= 1'b0; blk <= 1'b0;
      cnt <= '0; sh <= '0; op <= '0; data <= '0; osh <= '0; addr <= '0;
      wel <= 1'b0; bp <= 2'b00; busy_cnt <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;

      if (cs_n)      hold_act <= 1'b0;
      else if (!sck) hold_act <= ~hold_n;

      if (~cs_n & cs_q) blk <= busy;

      if (cs_n) cnt <= '0;
      else if (rise && cnt != '1) cnt <= cnt + 16'd1;

      if (rise) begin
        sh <= {sh[14:0], mosi};
        if (cnt == 16'd7)  op   <= {sh[6:0], mosi};
        if (cnt == 16'd23) addr <= {sh[AW-2:0], mosi};
        if ((op == OP_WRITE && cnt == 16'd31) || (op == OP_WRSR && cnt == 16'd15))
          data <= {sh[6:0], mosi};
      end

      if (fall) begin
        if (out_phase && cnt[2:0] == 3'd0) begin
          osh <= (op == OP_RDSR) ? status : mem[addr];
          if (op == OP_READ) addr <= addr + 1'b1;
        end else begin
          osh <= {osh[6:0], 1'b0};
        end
      end

      if (end_ok && cnt == 16'd8 && op == OP_WREN)      wel <= 1'b1;
      else if (end_ok && cnt == 16'd8 && op == OP_WRDI) wel <= 1'b0;
      else if (wr_frm)                                  wel <= 1'b0;

      if (sr_we && wp_n) bp <= data[3:2];

      if (we || sr_we) busy_cnt <= BCW'(BUSY_CYC);
      else if (busy)   busy_cnt <= busy_cnt - 1'b1;
    end
  end
endmodule

module spi_eeprom_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cs_n,
  input logic       wp_n,
  input logic       wel,
  input logic [1:0] bp,
  input logic       we,
  input logic       busy,
  input logic       hold_act
);
  AST_LATCH_SET_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_n) && !$past(cs_n, 2));  // R2
  AST_WRITE_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !wel);  // R4
  AST_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> wel);  // R6
  AST_NO_WRITE_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> bp != 2'b11);  // R7
  AST_PROTECT_HELD_BY_WP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $past(wp_n));  // R8
  AST_COMMIT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> busy);  // R9
  AST_HOLD_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_act) |-> !$past(sck));  // R10
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk chk_i (.*);

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb_top;
  typedef logic [7:0] u8;
  localparam int BUSY = 600;
  localparam int H    = 4;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0, hold_n = 1, wp_n = 1;
  logic miso, miso_en;

  spi_eeprom_slave #(.BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .hold_n(hold_n), .wp_n(wp_n), .miso(miso), .miso_en(miso_en));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  u8  mem_m [int];
  logic [1:0] bp_m = 0;
  logic wel_m = 0, busy_m = 0, no_wait = 0, done = 0;
  int hold_pos = -1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done && cs_n) chk(miso_en == 1'b0, "R11 idle enable", miso_en, 0);

  function automatic logic prot_m(input int a);
    int lo;
    lo = (bp_m == 2'b01) ? 'h600 : (bp_m == 2'b10) ? 'h400 : (bp_m == 2'b11) ? 0 : 'h800;
    return a >= lo;
  endfunction

  task automatic frame(input u8 q[$], input int extra, input string tag);
    u8 rx[$];
    u8 r;
    int bits, a, nb;
    nb = 0;
    @(negedge clk) cs_n = 0;
    repeat (H) @(negedge clk);
    foreach (q[k]) begin
      r = 0;
      for (int i = 7; i >= 0; i--) begin
        mosi = q[k][i];
        repeat (H) @(negedge clk);
        r = {r[6:0], miso};
        sck = 1;
        repeat (H) @(negedge clk);
        sck = 0;
        nb++;
        if (nb == hold_pos) begin
          @(negedge clk) hold_n = 0;
          repeat (H) @(negedge clk);
          for (int j = 0; j < 3; j++) begin
            sck = 1; mosi = ~mosi;
            repeat (H) @(negedge clk);
            chk(miso_en == 0, "R10 enable during hold", miso_en, 0);
            sck = 0;
            repeat (H) @(negedge clk);
          end
          hold_n = 1;
          repeat (H) @(negedge clk);
        end
      end
      rx.push_back(r);
    end
    for (int i = 0; i < extra; i++) begin
      mosi = 1; repeat (H) @(negedge clk); sck = 1; repeat (H) @(negedge clk); sck = 0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1;
    repeat (H) @(negedge clk);

    bits = 8 * q.size() + extra;
    a = (q.size() >= 3) ? ({q[1], q[2]} & 'h7FF) : 0;
    if (busy_m && q[0] != 8'h05) return;
    case (q[0])
      8'h05: for (int k = 1; k < rx.size(); k++)
               chk(rx[k] == {4'b0, bp_m, wel_m, busy_m}, tag, rx[k], {4'b0, bp_m, wel_m, busy_m});
      8'h03: for (int k = 3; k < rx.size(); k++)
               chk(rx[k] == mem_m[(a + k - 3) % 2048], tag, rx[k], mem_m[(a + k - 3) % 2048]);
      8'h06: if (bits == 8) wel_m = 1;
      8'h04: if (bits == 8) wel_m = 0;
      8'h02: begin
        if (bits % 8 == 0 && bits >= 32 && wel_m && !prot_m(a)) begin
          mem_m[a] = q[3]; busy_m = 1;
        end
        wel_m = 0;
      end
      8'h01: begin
        if (bits % 8 == 0 && bits >= 16 && wel_m) begin
          if (wp_n) bp_m = q[1][3:2];
          busy_m = 1;
        end
        wel_m = 0;
      end
      default: ;
    endcase
    if (busy_m && !no_wait) begin
      repeat (BUSY + 20) @(negedge clk);
      busy_m = 0;
    end
  endtask

  task automatic wr(input int a, input u8 d, input string tag);
    frame('{8'h06}, 0, tag);
    frame('{8'h02, u8'(a >> 8), u8'(a), d}, 0, tag);
  endtask

  task automatic rd(input int a, input int n, input string tag);
    u8 q[$];
    q = '{8'h03, u8'(a >> 8), u8'(a)};
    for (int i = 0; i < n; i++) q.push_back(8'h00);
    frame(q, 0, tag);
  endtask

  task automatic sr(input u8 d, input string tag);
    frame('{8'h06}, 0, tag);
    frame('{8'h01, d}, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(miso_en == 0, "R1 reset enable", miso_en, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    frame('{8'h05, 8'h00}, 0, "R1 reset status");

    frame('{8'h06}, 0, "R2 wren");
    frame('{8'h05, 8'h00, 8'h00}, 0, "R2 status latch set");
    frame('{8'h04}, 0, "R2 wrdi");
    frame('{8'h05, 8'h00}, 0, "R2 status latch clear");

    wr('h010, 8'h11, "R4 write");
    frame('{8'h02, 8'h00, 8'h10, 8'h22}, 0, "R6 no latch");
    rd('h010, 1, "R6 readback");

    wr('h7FF, 8'hA7, "R4 write");
    wr('h000, 8'h3C, "R4 write");
    wr('h5FF, 8'h5F, "R4 write");
    wr('h600, 8'h60, "R4 write");
    wr('h3FF, 8'h3F, "R4 write");
    wr('h400, 8'h40, "R4 write");
    wr('hF001, 8'hE1, "R3 high address bits ignored");
    rd('h7FF, 3, "R3 wrap read");
    rd('h3FF, 2, "R3 sequential read");
    frame('{8'h05, 8'h00}, 0, "R4 latch cleared after write");

    frame('{8'h06}, 0, "R5 wren");
    frame('{8'h02, 8'h00, 8'h10, 8'h77}, 3, "R5 stray bits");
    frame('{8'h05, 8'h00}, 0, "R5 latch cleared");
    rd('h010, 1, "R5 readback");

    sr(8'h04, "R8 set code 01");
    frame('{8'h05, 8'h00}, 0, "R8 status code 01");
    wr('h5FF, 8'hA5, "R7 below upper quarter");
    wr('h600, 8'hB6, "R7 upper quarter");
    rd('h5FF, 2, "R7 code 01 readback");
    sr(8'h08, "R8 set code 10");
    wr('h400, 8'hC4, "R7 upper half");
    wr('h3FF, 8'hC3, "R7 below upper half");
    rd('h3FF, 2, "R7 code 10 readback");
    sr(8'h0C, "R8 set code 11");
    wr('h000, 8'hD0, "R7 whole array");
    rd('h000, 1, "R7 code 11 readback");

    wp_n = 0;
    sr(8'h00, "R8 locked write status");
    frame('{8'h05, 8'h00}, 0, "R8 code held");
    wp_n = 1;
    sr(8'h00, "R8 unlocked");
    frame('{8'h05, 8'h00}, 0, "R8 code cleared");

    no_wait = 1;
    wr('h020, 8'h99, "R9 write");
    frame('{8'h06}, 0, "R9 wren ignored");
    frame('{8'h05, 8'h00, 8'h00}, 0, "R9 busy status");
    repeat (BUSY + 20) @(negedge clk);
    busy_m = 0;
    no_wait = 0;
    frame('{8'h05, 8'h00}, 0, "R9 idle status");
    rd('h020, 1, "R9 readback");

    hold_pos = 36;
    rd('h3FF, 3, "R10 read across hold");
    hold_pos = -1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule